// File: doc/BRIEF.md
# Auto-Acknowledging Prioritized Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt lines (64 by default) and presents them to one CPU through a word-organised register space on a simple single-cycle bus. Each line has one mask bit and one software-pending bit. The line's effective request is the hardware input ORed with its software bit, and a line is pending when that request is high and its mask bit is 0. A single interrupt output tells the CPU that at least one line is pending.

The CPU services interrupts by reading the event register. The read returns the lowest-numbered pending line and, as a side effect, sets that line's mask bit. The same line is therefore not reported again until software clears the mask once it has finished servicing it. Mask and software-pending bits are changed through separate write-one-to-set and write-one-to-clear banks, so that no read-modify-write is needed. Each line also has a stored target-CPU field. Only CPU 0 is served, so this field does not affect delivery.

The bus side is a two-state response machine. In `S_IDLE` no read data is presented. Any read that is accepted at a clock edge moves it to `S_RESP` (transition *read accepted*). In that state `bus_rvalid` is high for one cycle with the captured data. On the following edge it goes back to `S_IDLE` (transition *response done*), unless another read is accepted at that edge, in which case it stays in `S_RESP` (transition *back-to-back read*).

Top module: `prio_irq_ctrl`

## Requirements
- R1: `irq_out` is high in the same cycle whenever some line has (`irq_lines[n]` OR software-pending bit n) = 1 and mask bit n = 0. It falls combinationally when the hardware line drops.
- R2: A write to the mask-set bank at byte address 0x100+4w sets the mask bit of line 32w+b for each 1 in bit b of the data. The mask-clear bank at 0x180+4w clears those bits. Data bits that are 0 leave their bits unchanged. A read of either bank returns the current mask word w.
- R3: The software-set bank at 0x200+4w and the software-clear bank at 0x280+4w use the same word and bit layout to set or clear software-pending bits. Reading either returns the pending word. A set software bit raises a request exactly like the hardware line.
- R4: When several lines are pending, the event register reports the lowest line number.
- R5: A read of the event register at 0x004 while a line is pending returns the type 1 in bits 31:16 and the line number in bits 15:0.
- R6: A read of the event register while nothing is pending returns 0 and changes no mask bit.
- R7: An event read that reports line n sets mask bit n at the same edge. `irq_out` and later event reads then reflect the next pending line.
- R8: After reset all mask bits are 1, all software-pending bits are 0 and all target fields are 0.
- R9: The info register at 0x000 reads the number of implemented lines in bits 15:0 and 0 in bits 31:16.
- R10: The target field of line n lives at 0x400+4n. It stores the low TGT_W bits (4 by default) of the written data and reads them back zero-extended, and it has no effect on `irq_out`.
- R11: Read data appears on `bus_rdata` with `bus_rvalid` = 1 exactly one cycle after the read is accepted. Writes give no `bus_rvalid`. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Level-sensitive hardware interrupt requests |
| bus_valid | input | 1 | Access request, accepted at the clock edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe |
| irq_out | output | 1 | Interrupt request to CPU 0 |

## Verification
`irq_out` is combinational from the line inputs and from the registered mask and software bits. The bench therefore samples it 1 ns after the edge that commits a write, and directly after a change of a hardware line. Read data and `bus_rvalid` are registered once, so each read task drives the request at a falling edge and samples the response 1 ns after the next rising edge. The auto-mask of an event read takes effect at that same edge, so the next read or `irq_out` sample already shows the following line.

// File: rtl/icu_pkg.sv
`timescale 1ns/1ps
package icu_pkg;
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_INFO,
        ACC_EVENT,
        ACC_MASK_SET,
        ACC_MASK_CLR,
        ACC_SOFT_SET,
        ACC_SOFT_CLR,
        ACC_TARGET
    } acc_kind_e;

    typedef enum logic {
        S_IDLE,
        S_RESP
    } rsp_state_e;

    localparam logic [15:0] EVT_TYPE_HW = 16'd1;
endpackage

// File: rtl/icu_decode.sv
`timescale 1ns/1ps
module icu_decode
    import icu_pkg::*;
(
    input  logic [11:0] addr,
    output acc_kind_e   kind,
    output logic [4:0]  word,
    output logic [7:0]  tline
);
    always_comb begin
        word  = addr[6:2];
        tline = addr[9:2];
        kind  = ACC_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr[11:10] == 2'b01) begin
                kind = ACC_TARGET;
            end else if (addr[11:10] == 2'b00) begin
                unique case (addr[9:7])
                    3'd0: begin
                        if (addr[6:2] == 5'd0)      kind = ACC_INFO;
                        else if (addr[6:2] == 5'd1) kind = ACC_EVENT;
                    end
                    3'd2:    kind = ACC_MASK_SET;
                    3'd3:    kind = ACC_MASK_CLR;
                    3'd4:    kind = ACC_SOFT_SET;
                    3'd5:    kind = ACC_SOFT_CLR;
                    default: kind = ACC_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/icu_bitbank.sv
`timescale 1ns/1ps
module icu_bitbank #(
    parameter int   NUM_LINES = 64,
    parameter logic RST_VAL   = 1'b0,
    localparam int  IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic                 clr_en,
    input  logic [4:0]           word,
    input  logic [31:0]          wdata,
    input  logic                 auto_en,
    input  logic [IDX_W-1:0]     auto_idx,
    input  logic [4:0]           rd_word,
    output logic [NUM_LINES-1:0] bits,
    output logic [31:0]          rd_bits
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= {NUM_LINES{RST_VAL}};
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (set_en && word == 5'(i / 32) && wdata[i % 32])
                    bits[i] <= 1'b1;
                else if (clr_en && word == 5'(i / 32) && wdata[i % 32])
                    bits[i] <= 1'b0;
                // acknowledge-side masking is placed last so it wins
                if (auto_en && auto_idx == IDX_W'(i))
                    bits[i] <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_bits = '0;
        for (int b = 0; b < 32; b++) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (i % 32 == b && rd_word == 5'(i / 32))
                    rd_bits[b] = bits[i];
            end
        end
    end
endmodule

// File: rtl/icu_prio.sv
`timescale 1ns/1ps
module icu_prio #(
    parameter int  NUM_LINES = 64,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import icu_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int TGT_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic                 irq_out
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    acc_kind_e             kind;
    logic [4:0]            word;
    logic [7:0]            tline;
    logic [NUM_LINES-1:0]  mask_bits, soft_bits, pend;
    logic [31:0]           mask_rd, soft_rd, rd_next;
    logic                  win_any, rd_fire, wr_fire, evt_ack;
    logic [IDX_W-1:0]      win_idx, tidx;
    logic [TGT_W-1:0]      tgt_q [NUM_LINES];
    rsp_state_e            state_q, state_d;

    icu_decode u_dec (
        .addr  (bus_addr),
        .kind  (kind),
        .word  (word),
        .tline (tline)
    );

    assign rd_fire = bus_valid && !bus_write;
    assign wr_fire = bus_valid && bus_write;
    assign evt_ack = rd_fire && (kind == ACC_EVENT) && win_any;

    icu_bitbank #(.NUM_LINES(NUM_LINES), .RST_VAL(1'b1)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (wr_fire && kind == ACC_MASK_SET),
        .clr_en   (wr_fire && kind == ACC_MASK_CLR),
        .word     (word),
        .wdata    (bus_wdata),
        .auto_en  (evt_ack),
        .auto_idx (win_idx),
        .rd_word  (word),
        .bits     (mask_bits),
        .rd_bits  (mask_rd)
    );

    icu_bitbank #(.NUM_LINES(NUM_LINES), .RST_VAL(1'b0)) u_soft (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (wr_fire && kind == ACC_SOFT_SET),
        .clr_en   (wr_fire && kind == ACC_SOFT_CLR),
        .word     (word),
        .wdata    (bus_wdata),
        .auto_en  (1'b0),
        .auto_idx ('0),
        .rd_word  (word),
        .bits     (soft_bits),
        .rd_bits  (soft_rd)
    );

    assign pend = (irq_lines | soft_bits) & ~mask_bits;

    icu_prio #(.NUM_LINES(NUM_LINES)) u_prio (
        .req (pend),
        .any (win_any),
        .idx (win_idx)
    );

    assign irq_out = win_any;
    assign tidx    = IDX_W'(tline);

    // target-CPU fields: stored and read back only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) tgt_q[i] <= '0;
        end else if (wr_fire && kind == ACC_TARGET && int'(tline) < NUM_LINES) begin
            tgt_q[tidx] <= bus_wdata[TGT_W-1:0];
        end
    end

    always_comb begin
        rd_next = '0;
        unique case (kind)
            ACC_INFO:                   rd_next = {16'h0, 16'(NUM_LINES)};
            ACC_EVENT:                  rd_next = win_any ? {EVT_TYPE_HW, 16'(win_idx)} : 32'h0;
            ACC_MASK_SET, ACC_MASK_CLR: rd_next = mask_rd;
            ACC_SOFT_SET, ACC_SOFT_CLR: rd_next = soft_rd;
            ACC_TARGET:                 rd_next = (int'(tline) < NUM_LINES) ? 32'(tgt_q[tidx]) : 32'h0;
            default:                    rd_next = '0;
        endcase
    end

    // response state machine: state register
    always_comb state_d = rd_fire ? S_RESP : S_IDLE;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // response state machine: outputs
    always_ff @(posedge clk) begin
        if (!rst_n)       bus_rdata <= '0;
        else if (rd_fire) bus_rdata <= rd_next;
        else              bus_rdata <= '0;
    end

    always_comb begin
        unique case (state_q)
            S_RESP:  bus_rvalid = 1'b1;
            default: bus_rvalid = 1'b0;
        endcase
    end

    AST_AUTO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ack |=> mask_bits[$past(win_idx)]); // R7
    AST_EMPTY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && kind == ACC_EVENT && !irq_out) |=> (bus_rdata == 32'h0)); // R6
    AST_EVENT_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && kind == ACC_EVENT && irq_out) |=> (bus_rdata[31:16] == 16'd1)); // R5
    AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && kind == ACC_SOFT_SET && word == 5'd0 && bus_wdata[0]) |=> soft_bits[0]); // R3
    AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> bus_rvalid); // R11
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_fire) |=> !bus_rvalid); // R11
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_lines = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prio_irq_ctrl #(.NUM_LINES(N), .TGT_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_valid = 1'b0;
        chk("R11 rvalid after read", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq idle", 32'(irq_out), 0);
        rd(12'h100, d); chk("R8 mask word0", d, 32'hFFFF_FFFF);
        rd(12'h184, d); chk("R8 mask word1", d, 32'hFFFF_FFFF);
        rd(12'h200, d); chk("R8 soft word0", d, 0);
        rd(12'h420, d); chk("R8 target", d, 0);
        rd(12'h000, d); chk("R9 info", d, 32'd64);
        rd(12'h004, d); chk("R6 empty event", d, 0);
    endtask

    task automatic t_single;
        logic [31:0] d;
        irq_lines[5] = 1'b1; #1;
        chk("R1 masked line no irq", 32'(irq_out), 0);
        rd(12'h004, d); chk("R6 masked event", d, 0);
        rd(12'h100, d); chk("R6 mask untouched", d, 32'hFFFF_FFFF);
        wr(12'h180, 32'h20);
        chk("R1 irq after unmask", 32'(irq_out), 1);
        rd(12'h004, d); chk("R5 event line5", d, 32'h0001_0005);
        chk("R7 irq drops after ack", 32'(irq_out), 0);
        rd(12'h100, d); chk("R7 mask bit5 set", d, 32'hFFFF_FFFF);
        irq_lines[5] = 1'b0;
    endtask

    task automatic t_priority;
        logic [31:0] d;
        irq_lines[3] = 1'b1; irq_lines[40] = 1'b1;
        wr(12'h184, 32'h100);
        wr(12'h180, 32'h8);
        rd(12'h004, d); chk("R4 lowest first", d, 32'h0001_0003);
        chk("R7 irq still for 40", 32'(irq_out), 1);
        rd(12'h004, d); chk("R7 next line 40", d, 32'h0001_0028);
        rd(12'h004, d); chk("R6 drained", d, 0);
        irq_lines[3] = 1'b0; irq_lines[40] = 1'b0;
    endtask

    task automatic t_mask_banks;
        logic [31:0] d;
        wr(12'h184, 32'h100);
        irq_lines[40] = 1'b1; #1;
        chk("R1 level high", 32'(irq_out), 1);
        irq_lines[40] = 1'b0; #1;
        chk("R1 level dropped", 32'(irq_out), 0);
        wr(12'h104, 32'h0);
        rd(12'h104, d); chk("R2 zero bits ignored", d, 32'hFFFF_FEFF);
        wr(12'h104, 32'h100);
        rd(12'h184, d); chk("R2 set restored", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_soft;
        logic [31:0] d;
        wr(12'h204, 32'h8000_0000);
        rd(12'h284, d); chk("R3 soft readback", d, 32'h8000_0000);
        chk("R3 soft masked", 32'(irq_out), 0);
        wr(12'h184, 32'h8000_0000);
        chk("R3 soft raises irq", 32'(irq_out), 1);
        rd(12'h004, d); chk("R3 soft event line63", d, 32'h0001_003F);
        chk("R7 soft acked", 32'(irq_out), 0);
        wr(12'h284, 32'h8000_0000);
        rd(12'h204, d); chk("R3 soft cleared", d, 0);
        wr(12'h184, 32'h8000_0000);
        chk("R3 no request after clear", 32'(irq_out), 0);
        wr(12'h104, 32'h8000_0000);
    endtask

    task automatic t_target;
        logic [31:0] d;
        wr(12'h41C, 32'h3);
        rd(12'h41C, d); chk("R10 target store", d, 32'h3);
        wr(12'h41C, 32'hFF);
        rd(12'h41C, d); chk("R10 target width", d, 32'hF);
        rd(12'h420, d); chk("R10 neighbour untouched", d, 0);
        chk("R10 no irq effect", 32'(irq_out), 0);
    endtask

    task automatic t_bus;
        logic [31:0] d;
        wr(12'h180, 32'h0);
        chk("R11 no rvalid on write", 32'(bus_rvalid), 0);
        rd(12'h300, d); chk("R11 unmapped zero", d, 0);
        @(posedge clk); #1;
        chk("R11 rvalid single", 32'(bus_rvalid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_single();
        t_priority();
        t_mask_banks();
        t_soft();
        t_target();
        t_bus();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule